// File: doc/BRIEF.md
# Bus Fault Register Capture

This block holds a 16-bit fault register that records error reports from the bus. Three active-low error lines are checked at the moment a bus cycle closes, which is the low-to-high transition of the active-low busy line. Each error is routed to a register bit chosen by two things: whether this processor owns the cycle, and whether the cycle is a memory or an I/O access. Cycles driven by other bus masters are watched as well, so faults raised in those cycles are also recorded.

Two system fault inputs arrive with no fixed timing relation to the clock. Each passes through a synchroniser and sets its own bits once per rising transition. Bits stay set until software clears them through a masked clear port. Two registered flags, major error and unrecoverable error, each report whether any captured bit falls inside a configurable mask.

Register numbering puts flag 0 at the most significant position: flag k appears on `rd_data[15-k]`, and the same order is used by `clr_mask` and by the mask parameters.

Top module: `bus_fault_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the register, `major_err` and `unrcv_err` are all cleared to 0 at that edge.
- R2: The error inputs are sampled only at the clock edge where `busy_n` is seen high after being low on the previous edge. An error held active while `busy_n` stays low or stays high, and removed before that edge, records nothing.
- R3: A protect error (`prot_err_n`=0) at the capture edge sets flag 0 (`rd_data[15]`) when `cpu_cycle`=1, and flag 1 (`rd_data[14]`) when `cpu_cycle`=0.
- R4: A parity error (`par_err_n`=0) at the capture edge sets flag 2 (`rd_data[13]`), whoever owns the cycle.
- R5: An address error (`addr_err_n`=0) at the capture edge sets flag 5 (`rd_data[10]`) when `mem_cycle`=1, and flag 8 (`rd_data[7]`) when `mem_cycle`=0.
- R6: A rising transition on `sys_flt0` sets flag 7 (`rd_data[8]`) at the third clock edge after the input is first sampled high, and not earlier. Holding the input high sets the flag only once, so a clear made while it stays high is not undone.
- R7: A rising transition on `sys_flt1` sets flags 13 and 15 (`rd_data[2]` and `rd_data[0]`) with the same timing and single-shot behaviour as R6.
- R8: Captured bits are sticky. They stay set while `clr_en` is 0, and captures from separate cycles accumulate by OR.
- R9: With `clr_en`=1, each register bit whose `clr_mask` bit is 1 is cleared at that edge, and all other bits are kept. A bit being set in the same cycle is set, not cleared.
- R10: `major_err` equals the OR of (register AND `MAJOR_MASK`, default 16'h2580: flags 2, 5, 7, 8). `unrcv_err` equals the OR of (register AND `UNRCV_MASK`, default 16'hC005: flags 0, 1, 13, 15). Both change in the same cycle as `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_n | input | 1 | Active-low bus busy; a low-to-high transition closes a cycle |
| cpu_cycle | input | 1 | 1 when this processor owns the current cycle |
| mem_cycle | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| prot_err_n | input | 1 | Active-low memory protect error |
| par_err_n | input | 1 | Active-low memory parity error |
| addr_err_n | input | 1 | Active-low external address error |
| sys_flt0 | input | 1 | Asynchronous system fault 0, rising-edge active |
| sys_flt1 | input | 1 | Asynchronous system fault 1, rising-edge active |
| clr_en | input | 1 | Apply `clr_mask` this cycle |
| clr_mask | input | 16 | Bits to clear, in register order |
| rd_data | output | 16 | Fault register contents (flag 0 at bit 15) |
| major_err | output | 1 | Registered major error flag |
| unrcv_err | output | 1 | Registered unrecoverable error flag |

## Verification
The hardest case to reach from the ports is the cycle in which a fault is captured and a clear hits the same bit. It needs a busy trailing edge, an active error input and `clr_en` all lined up on one clock edge. The bench builds this by driving all three on the same falling clock edge, with the register preloaded with other flags, so that set priority and clearing of the untouched bits are both visible. A second case that is hard to observe is a system fault held high across a clear. The bench shows single-shot behaviour by clearing and then waiting several cycles with the input still high.

// File: rtl/fltreg_pkg.sv
package fltreg_pkg;
  localparam int REG_W = 16;
  typedef logic [REG_W-1:0] freg_t;

  // flag numbers (flag 0 is the most significant register bit)
  localparam int F_PROT_OWN = 0;
  localparam int F_PROT_OTH = 1;
  localparam int F_PARITY   = 2;
  localparam int F_ADDR_MEM = 5;
  localparam int F_SYS0     = 7;
  localparam int F_ADDR_IO  = 8;
  localparam int F_SYS1_LO  = 13;
  localparam int F_SYS1_HI  = 15;

  function automatic freg_t flag_bit(input int k);
    freg_t v;
    v = '0;
    v[REG_W-1-k] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/flt_sync_edge.sv
module flt_sync_edge #(
  parameter int NUM_CH = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] async_in,
  output logic [NUM_CH-1:0] rise
);
  localparam int LAST = STAGES;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [LAST:0] shreg;
    always_ff @(posedge clk) begin
      if (rst) shreg <= '0;
      else     shreg <= {shreg[LAST-1:0], async_in[i]};
    end
    // synchronised level vs. its delayed copy
    assign rise[i] = shreg[LAST-1] & ~shreg[LAST];
  end
endmodule

// File: rtl/flt_busy_capture.sv
module flt_busy_capture
  import fltreg_pkg::*;
(
  input  logic  clk,
  input  logic  busy_n,
  input  logic  cpu_cycle,
  input  logic  mem_cycle,
  input  logic  prot_err_n,
  input  logic  par_err_n,
  input  logic  addr_err_n,
  output logic  cycle_end,
  output freg_t bus_set
);
  logic busy_q;

  // plain tracking flop: the previous level of busy
  always_ff @(posedge clk) busy_q <= busy_n;

  assign cycle_end = ~busy_q & busy_n;

  always_comb begin
    bus_set = '0;
    if (cycle_end) begin
      if (!prot_err_n)
        bus_set |= cpu_cycle ? flag_bit(F_PROT_OWN) : flag_bit(F_PROT_OTH);
      if (!par_err_n)
        bus_set |= flag_bit(F_PARITY);
      if (!addr_err_n)
        bus_set |= mem_cycle ? flag_bit(F_ADDR_MEM) : flag_bit(F_ADDR_IO);
    end
  end
endmodule

// File: rtl/flt_store.sv
module flt_store
  import fltreg_pkg::*;
#(
  parameter freg_t MAJOR_MASK = 16'h2580,
  parameter freg_t UNRCV_MASK = 16'hC005
) (
  input  logic  clk,
  input  logic  rst,
  input  freg_t set_vec,
  input  logic  clr_en,
  input  freg_t clr_mask,
  output freg_t q,
  output logic  major_err,
  output logic  unrcv_err
);
  freg_t q_next;
  freg_t kill;

  always_comb begin
    kill   = clr_en ? clr_mask : '0;
    // set has priority over clear
    q_next = (q & ~kill) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q         <= '0;
      major_err <= 1'b0;
      unrcv_err <= 1'b0;
    end else begin
      q         <= q_next;
      major_err <= |(q_next & MAJOR_MASK);
      unrcv_err <= |(q_next & UNRCV_MASK);
    end
  end
endmodule

// File: rtl/bus_fault_reg.sv
module bus_fault_reg
  import fltreg_pkg::*;
#(
  parameter logic [15:0] MAJOR_MASK  = 16'h2580,
  parameter logic [15:0] UNRCV_MASK  = 16'hC005,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        busy_n,
  input  logic        cpu_cycle,
  input  logic        mem_cycle,
  input  logic        prot_err_n,
  input  logic        par_err_n,
  input  logic        addr_err_n,
  input  logic        sys_flt0,
  input  logic        sys_flt1,
  input  logic        clr_en,
  input  logic [15:0] clr_mask,
  output logic [15:0] rd_data,
  output logic        major_err,
  output logic        unrcv_err
);
  localparam int NUM_SYS = 2;

  logic [NUM_SYS-1:0] sys_rise;
  logic               cycle_end;
  freg_t              bus_set;
  freg_t              sys_set;
  freg_t              set_all;

  flt_sync_edge #(.NUM_CH(NUM_SYS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({sys_flt1, sys_flt0}),
    .rise     (sys_rise)
  );

  flt_busy_capture u_cap (
    .clk        (clk),
    .busy_n     (busy_n),
    .cpu_cycle  (cpu_cycle),
    .mem_cycle  (mem_cycle),
    .prot_err_n (prot_err_n),
    .par_err_n  (par_err_n),
    .addr_err_n (addr_err_n),
    .cycle_end  (cycle_end),
    .bus_set    (bus_set)
  );

  always_comb begin
    sys_set = '0;
    if (sys_rise[0]) sys_set |= flag_bit(F_SYS0);
    if (sys_rise[1]) sys_set |= flag_bit(F_SYS1_LO) | flag_bit(F_SYS1_HI);
    set_all = bus_set | sys_set;
  end

  flt_store #(.MAJOR_MASK(MAJOR_MASK), .UNRCV_MASK(UNRCV_MASK)) u_store (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_all),
    .clr_en    (clr_en),
    .clr_mask  (clr_mask),
    .q         (rd_data),
    .major_err (major_err),
    .unrcv_err (unrcv_err)
  );
endmodule

// File: rtl/bus_fault_reg_chk.sv
module bus_fault_reg_chk #(
  parameter logic [15:0] MAJOR_MASK = 16'h2580,
  parameter logic [15:0] UNRCV_MASK = 16'hC005
) (
  input logic        clk,
  input logic        rst,
  input logic        busy_n,
  input logic        cpu_cycle,
  input logic        prot_err_n,
  input logic        par_err_n,
  input logic        clr_en,
  input logic [15:0] clr_mask,
  input logic [15:0] set_all,
  input logic [15:0] rd_data,
  input logic        major_err,
  input logic        unrcv_err
);
  p_prot_own_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_n) && cpu_cycle && !prot_err_n) |=> rd_data[15]);

  p_prot_oth_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_n) && !cpu_cycle && !prot_err_n) |=> rd_data[14]);

  p_parity_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_n) && !par_err_n) |=> rd_data[13]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr_en) |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_en && set_all == 16'h0) |=> ((rd_data & $past(clr_mask)) == 16'h0));

  p_major_r10: assert property (@(posedge clk) disable iff (rst)
    major_err == (|(rd_data & MAJOR_MASK)));

  p_unrcv_r10: assert property (@(posedge clk) disable iff (rst)
    unrcv_err == (|(rd_data & UNRCV_MASK)));
endmodule

bind bus_fault_reg bus_fault_reg_chk #(
  .MAJOR_MASK(MAJOR_MASK),
  .UNRCV_MASK(UNRCV_MASK)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy_n     (busy_n),
  .cpu_cycle  (cpu_cycle),
  .prot_err_n (prot_err_n),
  .par_err_n  (par_err_n),
  .clr_en     (clr_en),
  .clr_mask   (clr_mask),
  .set_all    (set_all),
  .rd_data    (rd_data),
  .major_err  (major_err),
  .unrcv_err  (unrcv_err)
);

// File: tb/sim_bus_fault_reg.sv
`timescale 1ns/1ps
module sim_bus_fault_reg;
  localparam logic [15:0] MAJ_M = 16'h2580;
  localparam logic [15:0] UNR_M = 16'hC005;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy_n = 1'b1, cpu_cycle = 1'b1, mem_cycle = 1'b1;
  logic prot_err_n = 1'b1, par_err_n = 1'b1, addr_err_n = 1'b1;
  logic sys_flt0 = 1'b0, sys_flt1 = 1'b0;
  logic clr_en = 1'b0;
  logic [15:0] clr_mask = 16'h0;
  logic [15:0] rd_data;
  logic major_err, unrcv_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_fault_reg u0 (
    .clk(clk), .rst(rst), .busy_n(busy_n), .cpu_cycle(cpu_cycle),
    .mem_cycle(mem_cycle), .prot_err_n(prot_err_n), .par_err_n(par_err_n),
    .addr_err_n(addr_err_n), .sys_flt0(sys_flt0), .sys_flt1(sys_flt1),
    .clr_en(clr_en), .clr_mask(clr_mask), .rd_data(rd_data),
    .major_err(major_err), .unrcv_err(unrcv_err)
  );

  function automatic logic [15:0] fb(input int k);
    return 16'h8000 >> k;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic [15:0] reg_exp);
    chk({req, " reg"}, rd_data, reg_exp);
    chk({req, " R10 major"}, {15'h0, major_err}, {15'h0, |(reg_exp & MAJ_M)});
    chk({req, " R10 unrcv"}, {15'h0, unrcv_err}, {15'h0, |(reg_exp & UNR_M)});
  endtask

  task automatic clear_all();
    @(negedge clk); clr_en = 1'b1; clr_mask = 16'hFFFF;
    @(negedge clk); clr_en = 1'b0; clr_mask = 16'h0;
  endtask

  task automatic bus_cycle(input bit prot, input bit par, input bit adr,
                           input bit own, input bit mem);
    @(negedge clk); busy_n = 1'b0; cpu_cycle = own; mem_cycle = mem;
    @(negedge clk);
    prot_err_n = ~prot; par_err_n = ~par; addr_err_n = ~adr; busy_n = 1'b1;
    @(negedge clk);
    prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_flags("R1 reset", 16'h0);

    // R3/R4/R5 sweep: every error combination, owner and type
    for (int c = 0; c < 32; c++) begin
      bit p, q, a, o, m;
      {p, q, a, o, m} = c[4:0];
      clear_all();
      bus_cycle(p, q, a, o, m);
      exp = 16'h0;
      if (p) exp |= o ? fb(0) : fb(1);
      if (q) exp |= fb(2);
      if (a) exp |= m ? fb(5) : fb(8);
      chk_flags("R3/R4/R5 sweep", exp);
    end

    // R2: error removed before trailing edge is not captured
    clear_all();
    @(negedge clk); busy_n = 1'b0; prot_err_n = 1'b0; par_err_n = 1'b0; addr_err_n = 1'b0;
    @(negedge clk);
    @(negedge clk); prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
    @(negedge clk); busy_n = 1'b1;
    @(negedge clk);
    chk_flags("R2 error gone at edge", 16'h0);
    // R2: errors while bus idle (busy stays high)
    @(negedge clk); prot_err_n = 1'b0; par_err_n = 1'b0; addr_err_n = 1'b0;
    repeat (3) @(negedge clk);
    prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
    @(negedge clk);
    chk_flags("R2 idle errors", 16'h0);

    // R8: accumulation and stickiness
    bus_cycle(0, 1, 0, 1, 1);
    bus_cycle(1, 0, 0, 0, 1);
    chk_flags("R8 accumulate", fb(2) | fb(1));
    repeat (5) @(negedge clk);
    chk_flags("R8 sticky", fb(2) | fb(1));

    // R6: system fault 0 timing and single shot
    clear_all();
    @(negedge clk); sys_flt0 = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_flags("R6 not yet", 16'h0);
    @(negedge clk);
    chk_flags("R6 set", fb(7));
    clear_all();
    repeat (4) @(negedge clk);
    chk_flags("R6 held high once", 16'h0);
    sys_flt0 = 1'b0;
    repeat (4) @(negedge clk);
    chk_flags("R6 falling no effect", 16'h0);

    // R7: system fault 1
    @(negedge clk); sys_flt1 = 1'b1;
    repeat (3) @(negedge clk);
    chk_flags("R7 set", fb(13) | fb(15));
    clear_all();
    repeat (4) @(negedge clk);
    chk_flags("R7 held high once", 16'h0);
    sys_flt1 = 1'b0;
    @(negedge clk);

    // R9: partial clear keeps the rest
    bus_cycle(1, 1, 1, 1, 1);
    chk_flags("R9 preload", fb(0) | fb(2) | fb(5));
    @(negedge clk); clr_en = 1'b1; clr_mask = fb(2);
    @(negedge clk); clr_en = 1'b0; clr_mask = 16'h0;
    chk_flags("R9 partial clear", fb(0) | fb(5));
    // R9: set wins over clear in the same cycle
    @(negedge clk); busy_n = 1'b0; cpu_cycle = 1'b1;
    @(negedge clk); busy_n = 1'b1; par_err_n = 1'b0; clr_en = 1'b1; clr_mask = 16'hFFFF;
    @(negedge clk); par_err_n = 1'b1; clr_en = 1'b0; clr_mask = 16'h0;
    chk_flags("R9 set beats clear", fb(2));

    // R1: reset mid-run clears everything
    bus_cycle(1, 0, 1, 0, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_flags("R1 reset after faults", 16'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule